// File: doc/BRIEF.md
# Block Synchronization Protection Machine

This block follows a demodulated serial bit stream and decides whether block alignment is held. Each block carries 272 data bits followed by a 16-bit block identification code (BIC), so one block period is 288 bits. A position counter runs freely and predicts the bit at which the next BIC should end. A two-state machine compares every predicted BIC instant with the output of a BIC detector and raises a lock flag. It uses separate protection counts for acquiring lock and for holding it, so a single lost or spurious code does not flip the decision.

The detector compares the 16 most recent bits against a parameter set of valid BIC words. It declares a match when the Hamming distance to any word is within a tolerance, and the tolerance depends on whether lock is held. Each protection count register holds the wanted number of events minus one. The recommended settings are tolerance 2 in both states, acquire count 1 (two events) and hold count 7 (eight events). The configuration nibbles are plain inputs, and the soft clear leaves them unchanged.

Bits arrive on a strobe (`in_valid` with `in_bit`). Demodulated bits cannot be held back, so the block has no back-pressure and accepts every strobed bit. Clock cycles without a strobe leave all state unchanged, except for the effect of the soft clear.

Top module: `block_sync_top`

## Requirements
- R1: After reset `bit_pos` is 287, `locked` is 0 and `blk_start` is 0. Each strobed bit moves `bit_pos` one place forward, from 287 back to 0. Positions 272..287 are the BIC, and 287 is its last bit (the predicted instant). A cycle without a strobe leaves `bit_pos` unchanged.
- R2: `blk_start` is high for exactly one clock, in the same cycle in which `bit_pos` becomes 0.
- R3: A detection happens when the window {previous 15 bits, current bit} is within the tolerance of any BIC word. The newest bit sits at the LSB and the code is sent MSB first. The tolerance is `tol_hunt` while unlocked and `tol_hold` while locked.
- R4: While unlocked, a detection at a bit whose position would not be 287 re-phases the counter, so that bit takes position 287.
- R5: While unlocked, each detection is an agreement. If the protection count is already at least `prot_hunt`, the agreement sets `locked` and clears the count; otherwise it increments the count. A missing detection at the predicted instant clears the count.
- R6: While locked, only the predicted instant matters. A detection there clears the count. A miss there either clears `locked` (when the count is at least `prot_hold`) or increments the count. Detections at other positions neither re-phase the counter nor change the lock state.
- R7: A protection value of 0 makes a single qualifying event toggle the lock state.
- R8: A high `sync_clr` clears `locked` and the protection count at the next edge. It takes priority over a protection update from a bit in the same cycle. It does not change `bit_pos`, which still advances if a bit is strobed.
- R9: All outputs are registered and show the effect of a strobed bit from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Bit strobe |
| in_bit | input | 1 | Demodulated bit, valid with the strobe |
| tol_hunt | input | 4 | Tolerated BIC bit errors while unlocked |
| tol_hold | input | 4 | Tolerated BIC bit errors while locked |
| prot_hunt | input | 4 | Acquire event count minus one |
| prot_hold | input | 4 | Hold-loss event count minus one |
| sync_clr | input | 1 | Soft clear of lock state and protection count |
| locked | output | 1 | Block synchronization held |
| blk_start | output | 1 | One-clock pulse at position 0 of each predicted block |
| bit_pos | output | 9 | Position of the last accepted bit in the block period |

## Verification
Every result is due one clock after its cause. A strobed bit, or a `sync_clr` pulse, is taken at a rising edge, and `bit_pos`, `blk_start` and `locked` show the new value from that same edge. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. It compares all three outputs with the model on the next falling edge, so every comparison falls exactly one edge after the stimulus. Directed checks are made right after the last BIC bit of a block, the cycle in which the lock decision for that block becomes visible.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  localparam int BIC_W = 16;
  localparam int NUM_BIC = 4;
  localparam logic [NUM_BIC*BIC_W-1:0] BIC_SET_DEFAULT =
    {16'hC875, 16'hA791, 16'h74A6, 16'h135E};
  typedef enum logic {ST_HUNT, ST_HOLD} bsync_state_e;
endpackage

// File: rtl/bsync_bic_match.sv
module bsync_bic_match #(
  parameter int W = 16,
  parameter int N = 4,
  parameter int TW = 4,
  parameter logic [N*W-1:0] WORDS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic [TW-1:0] tol,
  output logic          hit
);
  logic [W-1:0] hist_q;
  logic [W-1:0] window;
  logic [N-1:0] near;

  assign window = {hist_q[W-2:0], in_bit};

  generate
    for (genvar i = 0; i < N; i++) begin : g_word
      logic [W-1:0] diff;
      assign diff    = window ^ WORDS[i*W +: W];
      assign near[i] = ($countones(diff) <= int'(tol));
    end
  endgenerate

  assign hit = in_valid && (|near);

  always_ff @(posedge clk) begin
    if (rst)           hist_q <= '0;
    else if (in_valid) hist_q <= window;
  end
endmodule

// File: rtl/bsync_pos_ctr.sv
module bsync_pos_ctr #(
  parameter int PERIOD = 288,
  parameter int PW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          rephase,
  output logic          at_pred,
  output logic          blk_start,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PERIOD - 2);

  logic [PW-1:0] pos_q;
  logic          blk_q;

  // the incoming bit lands on the last BIC position
  assign at_pred   = adv && (pos_q == PRE_LAST);
  assign pos       = pos_q;
  assign blk_start = blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= LAST;
      blk_q <= 1'b0;
    end else begin
      blk_q <= adv && !rephase && (pos_q == LAST);
      if (adv) begin
        if (rephase)            pos_q <= LAST;
        else if (pos_q == LAST) pos_q <= '0;
        else                    pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsync_fsm.sv
module bsync_fsm
  import bsync_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          at_pred,
  input  logic          hit,
  input  logic [CW-1:0] prot_hunt,
  input  logic [CW-1:0] prot_hold,
  output logic          locked,
  output logic          rephase
);
  bsync_state_e  state_q;
  logic [CW-1:0] cnt_q;

  assign locked  = (state_q == ST_HOLD);
  assign rephase = adv && !clr && (state_q == ST_HUNT) && hit && !at_pred;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else if (adv) begin
      if (state_q == ST_HUNT) begin
        if (hit) begin
          if (cnt_q >= prot_hunt) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (at_pred) begin
          cnt_q <= '0;
        end
      end else if (at_pred) begin
        if (hit) begin
          cnt_q <= '0;
        end else if (cnt_q >= prot_hold) begin
          state_q <= ST_HUNT;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/block_sync_top.sv
module block_sync_top
  import bsync_pkg::*;
#(
  parameter int DATA_BITS = 272,
  parameter int CW = 4,
  parameter logic [NUM_BIC*BIC_W-1:0] BIC_SET = BIC_SET_DEFAULT,
  parameter int PERIOD = DATA_BITS + BIC_W,
  parameter int POS_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic [CW-1:0]    tol_hunt,
  input  logic [CW-1:0]    tol_hold,
  input  logic [CW-1:0]    prot_hunt,
  input  logic [CW-1:0]    prot_hold,
  input  logic             sync_clr,
  output logic             locked,
  output logic             blk_start,
  output logic [POS_W-1:0] bit_pos
);
  logic          hit;
  logic          at_pred;
  logic          rephase;
  logic [CW-1:0] tol_sel;

  assign tol_sel = locked ? tol_hold : tol_hunt;

  bsync_bic_match #(.W(BIC_W), .N(NUM_BIC), .TW(CW), .WORDS(BIC_SET)) match_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .tol(tol_sel), .hit(hit)
  );

  bsync_pos_ctr #(.PERIOD(PERIOD), .PW(POS_W)) ctr_i (
    .clk(clk), .rst(rst), .adv(in_valid), .rephase(rephase),
    .at_pred(at_pred), .blk_start(blk_start), .pos(bit_pos)
  );

  bsync_fsm #(.CW(CW)) fsm_i (
    .clk(clk), .rst(rst), .clr(sync_clr), .adv(in_valid),
    .at_pred(at_pred), .hit(hit), .prot_hunt(prot_hunt),
    .prot_hold(prot_hold), .locked(locked), .rephase(rephase)
  );
endmodule

// File: rtl/block_sync_chk.sv
module block_sync_chk #(
  parameter int PERIOD = 288,
  parameter int POS_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             sync_clr,
  input logic             locked,
  input logic             blk_start,
  input logic [POS_W-1:0] bit_pos
);
  assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
    int'(bit_pos) < PERIOD);

  assert_pos_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(bit_pos));

  assert_blk_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> (bit_pos == '0));

  assert_blk_single_R2: assert property (@(posedge clk) disable iff (rst)
    blk_start |=> !blk_start);

  assert_lock_needs_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !sync_clr) |=> $stable(locked));

  assert_clr_unlocks_R8: assert property (@(posedge clk) disable iff (rst)
    sync_clr |=> !locked);
endmodule

bind block_sync_top block_sync_chk #(.PERIOD(PERIOD), .POS_W(POS_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sync_clr(sync_clr),
  .locked(locked), .blk_start(blk_start), .bit_pos(bit_pos)
);

// File: tb/block_sync_tb_top.sv
module block_sync_tb_top;
  localparam logic [15:0] BICS [4] = '{16'h135E, 16'h74A6, 16'hA791, 16'hC875};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, in_valid = 1'b0, in_bit = 1'b0, sync_clr = 1'b0;
  logic [3:0] tol_hunt = 4'd2, tol_hold = 4'd2, prot_hunt = 4'd1, prot_hold = 4'd7;
  logic       locked, blk_start;
  logic [8:0] bit_pos;

  block_sync_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .tol_hunt(tol_hunt), .tol_hold(tol_hold), .prot_hunt(prot_hunt),
    .prot_hold(prot_hold), .sync_clr(sync_clr), .locked(locked),
    .blk_start(blk_start), .bit_pos(bit_pos)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R5";
  bit    cmp_en = 1'b0, done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_win;
  int m_pos, m_cnt;
  bit m_lock, m_blk;
  always @(posedge clk) begin
    logic [15:0] w;
    int tol, nxt;
    bit hit, pred;
    if (rst) begin
      m_win = '0; m_pos = 287; m_cnt = 0; m_lock = 0; m_blk = 0;
    end else begin
      m_blk = 0;
      if (in_valid) begin
        w = {m_win[14:0], in_bit};
        m_win = w;
        tol = m_lock ? int'(tol_hold) : int'(tol_hunt);
        hit = 0;
        for (int k = 0; k < 4; k++) if ($countones(w ^ BICS[k]) <= tol) hit = 1;
        nxt = (m_pos == 287) ? 0 : m_pos + 1;
        pred = (nxt == 287);
        if (sync_clr) begin
          m_lock = 0; m_cnt = 0;
        end else if (!m_lock) begin
          if (hit) begin
            if (!pred) nxt = 287;
            if (m_cnt >= int'(prot_hunt)) begin m_lock = 1; m_cnt = 0; end
            else m_cnt++;
          end else if (pred) m_cnt = 0;
        end else if (pred) begin
          if (hit) m_cnt = 0;
          else if (m_cnt >= int'(prot_hold)) begin m_lock = 0; m_cnt = 0; end
          else m_cnt++;
        end
        m_pos = nxt;
        m_blk = (m_pos == 0);
      end else if (sync_clr) begin
        m_lock = 0; m_cnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R1/R9 bit_pos", int'(bit_pos), m_pos);
      chk("R2 blk_start", int'(blk_start), int'(m_blk));
      chk({cur_tag, " locked"}, int'(locked), int'(m_lock));
    end
  end

  task automatic send_bit(input logic b);
    in_valid = 1'b1; in_bit = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  task automatic send_bic(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_block(input logic [15:0] w);
    send_zeros(272);
    send_bic(w);
  endtask

  task automatic pulse_clr();
    sync_clr = 1'b1;
    @(negedge clk);
    sync_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    chk("R1 reset bit_pos", int'(bit_pos), 287);
    chk("R1 reset locked", int'(locked), 0);
    chk("R1 reset blk_start", int'(blk_start), 0);

    tol_hunt = 4'd0;
    cur_tag = "R5";
    send_block(BICS[0]);
    chk("R5 one agreement", int'(locked), 0);
    chk("R1 aligned end", int'(bit_pos), 287);
    send_block(BICS[1]);
    chk("R5 two agreements lock", int'(locked), 1);

    send_bit(1'b0);
    chk("R2 pulse", int'(blk_start), 1);
    chk("R2 position", int'(bit_pos), 0);
    send_zeros(271);
    cur_tag = "R3";
    send_bic(BICS[2] ^ 16'h0101);
    chk("R3 hold tolerance", int'(locked), 1);

    cur_tag = "R6";
    for (int b = 0; b < 7; b++) send_block(BICS[3] ^ 16'h0007);
    chk("R6 seven misses", int'(locked), 1);
    send_block(BICS[0]);
    for (int b = 0; b < 7; b++) send_block(BICS[1] ^ 16'h0007);
    chk("R6 count cleared", int'(locked), 1);
    send_block(BICS[1] ^ 16'h0007);
    chk("R6 eighth miss", int'(locked), 0);

    cur_tag = "R5";
    send_block(BICS[2]);
    send_zeros(288);
    send_block(BICS[3]);
    chk("R5 miss cleared count", int'(locked), 0);
    send_block(BICS[0]);
    chk("R5 relock", int'(locked), 1);

    cur_tag = "R6";
    send_zeros(84);
    send_bic(BICS[1]);
    send_zeros(100);
    chk("R6 no rephase when locked", int'(bit_pos), 199);
    chk("R6 lock kept", int'(locked), 1);
    send_zeros(72);
    send_bic(BICS[0]);
    chk("R6 still aligned", int'(bit_pos), 287);

    cur_tag = "R8";
    pulse_clr();
    chk("R8 clr unlocks", int'(locked), 0);
    chk("R8 clr keeps pos", int'(bit_pos), 287);
    send_block(BICS[2]);
    chk("R8 count cleared", int'(locked), 0);
    send_block(BICS[3]);
    chk("R8 relock", int'(locked), 1);

    cur_tag = "R7";
    prot_hold = 4'd0;
    send_block(BICS[0] ^ 16'h0007);
    chk("R7 single miss unlocks", int'(locked), 0);
    prot_hunt = 4'd0;
    send_block(BICS[1]);
    chk("R7 single hit locks", int'(locked), 1);
    prot_hunt = 4'd1;
    prot_hold = 4'd7;

    cur_tag = "R4";
    pulse_clr();
    send_zeros(100);
    send_bic(BICS[2]);
    chk("R4 rephase", int'(bit_pos), 287);
    chk("R4 first event", int'(locked), 0);
    send_block(BICS[3]);
    chk("R4 lock after rephase", int'(locked), 1);

    cur_tag = "R3";
    pulse_clr();
    tol_hunt = 4'd2;
    send_block(BICS[0] ^ 16'h0101);
    send_block(BICS[0] ^ 16'h0101);
    chk("R3 hunt tolerance 2", int'(locked), 1);
    pulse_clr();
    tol_hunt = 4'd0;
    send_block(BICS[0] ^ 16'h0101);
    send_block(BICS[0] ^ 16'h0101);
    chk("R3 hunt tolerance 0", int'(locked), 0);

    cur_tag = "R5";
    tol_hunt = 4'd2;
    pulse_clr();
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int b = 0; b < 4; b++) begin
        for (int i = 0; i < 272; i++) begin
          send_bit(lfsr[0]);
          lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
          if (i % 37 == 0) repeat (2) @(negedge clk);
        end
        send_bic(BICS[b]);
      end
    end
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule